// File: doc/BRIEF.md
# Flash Program Controller with Sector Protection

This block sits between a register bus and a simplified nonvolatile array model. Software first sets a program-enable bit in a small control register. It then issues a data write carrying an address, a data word and an access size. When the write is legal, the controller forwards it to the array for one cycle and holds a busy flag for a fixed number of clock cycles, which stands in for the cell programming time. When busy drops, an end-of-operation flag is set.

A write that breaks a rule never reaches the array. Such a write sets one or more error flags: sequence, parallelism, alignment or protection. Sector protection comes from a configuration word that holds one bit per sector, and a mode input selects how those bits are read. In one mode a 0 means the sector is write-protected. In the other mode a 1 means the sector is execute-only protected. Status flags are cleared by writing 1 to them, but the clear is refused while a burst of back-to-back writes is still pending.

A read-protection byte is decoded into a 2-bit level, and a debug-disable output is asserted at the highest level. Two interrupt outputs carry end-of-operation and error, and each is gated by its own enable bit.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset all six status flags, busy, the three control bits, both interrupts and `arr_we` are 0.
- R2: A data write is accepted when it arrives with busy low, program-enable set and no error. An accepted write drives `arr_we` high for exactly one cycle, starting the cycle after the write, with the write's address and data. Busy goes high on that same edge and stays high for PROG_CYC cycles.
- R3: When busy falls, status bit 0 (end of operation) is set on that same edge. `irq_eop` equals status bit 0 AND control bit 1 (end-of-operation enable).
- R4: A data write that arrives while busy is high or program-enable (control bit 0) is clear sets status bit 5 (sequence error). It does not write the array and does not change busy.
- R5: A data write that is otherwise allowed but whose `dat_size` differs from PSIZE sets status bit 4 (parallelism error). Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = doubleword.
- R6: A data write that is otherwise allowed but whose address is not a multiple of 2^`dat_size` bytes sets status bit 3 (alignment error).
- R7: The sector index is `dat_addr >> SECT_SHIFT`. With `cfg_prot_mode` = 0, a write to a sector whose `cfg_prot` bit is 0 sets status bit 2 (protection error). A write to a sector index of NSECT or above also sets status bit 2, in either mode. Any of the errors in R5 to R7 also sets status bit 0, and the write does not reach the array.
- R8: With `cfg_prot_mode` = 1, a sector whose `cfg_prot` bit is 1 is protected (status bit 2). A sector whose bit is 0 is writable.
- R9: If control bit 2 (error enable) is set when any of status bits 2 to 5 gets set, status bit 1 (operation error) is set too. `irq_err` equals status bit 1 AND control bit 2.
- R10: A register write with `reg_sel` = 1 clears each status bit 0 to 5 that has a 1 in `reg_wdata`. A flag that is set on the same edge stays set.
- R11: While `burst_pend` is high, status clear writes have no effect.
- R12: A `cfg_rdp` value of 0xAA gives `rdp_level` 0. A value of 0xCC gives `rdp_level` 2 and raises `dbg_disable`. Any other value gives `rdp_level` 1.
- R13: A register write with `reg_sel` = 0 loads `reg_wdata[2:0]` into the control bits, which are visible on `ctl`. Bit 0 is program-enable, bit 1 is end-of-operation enable and bit 2 is error enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | 6 | Register write data |
| dat_wr | input | 1 | Data write request |
| dat_addr | input | ADDR_W | Byte address of the data write |
| dat_size | input | 2 | Access size code |
| dat_wdata | input | DATA_W | Data to program |
| burst_pend | input | 1 | More writes of a burst are still pending |
| cfg_prot | input | NSECT | Per-sector protection bits |
| cfg_prot_mode | input | 1 | 0 = write protect (active low), 1 = execute-only (active high) |
| cfg_rdp | input | 8 | Read-protection byte |
| sts | output | 7 | {busy, seq, par, align, prot, operr, eop} |
| ctl | output | 3 | {error enable, eop enable, program enable} |
| irq_eop | output | 1 | End-of-operation interrupt |
| irq_err | output | 1 | Error interrupt |
| arr_we | output | 1 | Array write pulse |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| rdp_level | output | 2 | Decoded read-protection level |
| dbg_disable | output | 1 | High at read-protection level 2 |

## Verification
The assertions assume that the configuration inputs change only while no write is in flight. They also assume that `dat_wr` is a one-cycle strobe with its address, size and data all valid in that cycle. The stimulus changes configuration only after busy has dropped, and it holds every request for exactly one clock. A cycle-level reference model in the bench tracks status, busy and the array port. The bench compares that model with the design on each falling edge, across legal programs, back-to-back writes, each error cause, both protection modes and locked clears.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam int STS_W   = 6;
  localparam int ST_EOP  = 0;
  localparam int ST_OPER = 1;
  localparam int ST_PROT = 2;
  localparam int ST_ALGN = 3;
  localparam int ST_PAR  = 4;
  localparam int ST_SEQ  = 5;

  localparam int CTL_W   = 3;
  localparam int CT_PG   = 0;
  localparam int CT_EOPE = 1;
  localparam int CT_ERRE = 2;

  typedef enum logic [1:0] {
    RDP_OPEN   = 2'd0,
    RDP_LIMIT  = 2'd1,
    RDP_LOCKED = 2'd2
  } rdp_lvl_e;
endpackage

// File: rtl/fpc_busy_timer.sv
module fpc_busy_timer #(
  parameter int PROG_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(PROG_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(PROG_CYC - 1);
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/fpc_access_chk.sv
module fpc_access_chk #(
  parameter int          ADDR_W     = 16,
  parameter int          NSECT      = 12,
  parameter int          SECT_SHIFT = 12,
  parameter logic [1:0]  PSIZE      = 2'd2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [NSECT-1:0]  prot_bits,
  input  logic              prot_mode,
  output logic              err_par,
  output logic              err_align,
  output logic              err_prot
);
  localparam int SIDX_W = ADDR_W - SECT_SHIFT;

  logic [SIDX_W-1:0] sidx;
  logic [NSECT-1:0]  hit;

  assign sidx    = addr[ADDR_W-1:SECT_SHIFT];
  assign err_par = (size != PSIZE);

  always_comb begin
    case (size)
      2'd0:    err_align = 1'b0;
      2'd1:    err_align = addr[0];
      2'd2:    err_align = |addr[1:0];
      default: err_align = |addr[2:0];
    endcase
  end

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    logic locked;
    assign locked = prot_mode ? prot_bits[s] : ~prot_bits[s];
    assign hit[s] = locked && (int'(sidx) == s);
  end

  assign err_prot = (|hit) || (int'(sidx) >= NSECT);
endmodule

// File: rtl/fpc_rdp_decode.sv
module fpc_rdp_decode
  import flash_prog_pkg::*;
(
  input  logic [7:0] rdp_byte,
  output rdp_lvl_e   level,
  output logic       dbg_off
);
  always_comb begin
    case (rdp_byte)
      8'hAA:   level = RDP_OPEN;
      8'hCC:   level = RDP_LOCKED;
      default: level = RDP_LIMIT;
    endcase
  end

  assign dbg_off = (level == RDP_LOCKED);
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         DATA_W     = 32,
  parameter int         NSECT      = 12,
  parameter int         SECT_SHIFT = 12,
  parameter logic [1:0] PSIZE      = 2'd2,
  parameter int         PROG_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [5:0]        reg_wdata,
  input  logic              dat_wr,
  input  logic [ADDR_W-1:0] dat_addr,
  input  logic [1:0]        dat_size,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              burst_pend,
  input  logic [NSECT-1:0]  cfg_prot,
  input  logic              cfg_prot_mode,
  input  logic [7:0]        cfg_rdp,
  output logic [6:0]        sts,
  output logic [2:0]        ctl,
  output logic              irq_eop,
  output logic              irq_err,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [1:0]        rdp_level,
  output logic              dbg_disable
);
  logic [STS_W-1:0]  sts_q, sts_d, set_v, clr_v;
  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic              busy, tmr_done, accept;
  logic              e_par, e_algn, e_prot;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  rdp_lvl_e          lvl;

  fpc_busy_timer #(.PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .done(tmr_done)
  );

  fpc_access_chk #(
    .ADDR_W(ADDR_W), .NSECT(NSECT), .SECT_SHIFT(SECT_SHIFT), .PSIZE(PSIZE)
  ) u_chk (
    .addr(dat_addr), .size(dat_size), .prot_bits(cfg_prot),
    .prot_mode(cfg_prot_mode), .err_par(e_par), .err_align(e_algn),
    .err_prot(e_prot)
  );

  fpc_rdp_decode u_rdp (.rdp_byte(cfg_rdp), .level(lvl), .dbg_off(dbg_disable));

  always_comb begin
    ctl_d  = ctl_q;
    set_v  = '0;
    clr_v  = '0;
    accept = 1'b0;
    if (reg_wr && !reg_sel) ctl_d = reg_wdata[CTL_W-1:0];
    if (dat_wr) begin
      if (busy || !ctl_q[CT_PG]) begin
        set_v[ST_SEQ] = 1'b1;
      end else begin
        set_v[ST_PAR]  = e_par;
        set_v[ST_ALGN] = e_algn;
        set_v[ST_PROT] = e_prot;
        if (e_par || e_algn || e_prot) set_v[ST_EOP] = 1'b1;
        else                           accept        = 1'b1;
      end
    end
    if (tmr_done) set_v[ST_EOP] = 1'b1;
    if (ctl_q[CT_ERRE] && (|set_v[ST_SEQ:ST_PROT])) set_v[ST_OPER] = 1'b1;
    if (reg_wr && reg_sel && !burst_pend) clr_v = reg_wdata;
    sts_d = (sts_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ctl_q <= '0;
      we_q  <= 1'b0;
    end else begin
      sts_q <= sts_d;
      ctl_q <= ctl_d;
      we_q  <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= dat_addr;
      data_q <= dat_wdata;
    end
  end

  assign sts       = {busy, sts_q};
  assign ctl       = ctl_q;
  assign irq_eop   = sts_q[ST_EOP] & ctl_q[CT_EOPE];
  assign irq_err   = sts_q[ST_OPER] & ctl_q[CT_ERRE];
  assign arr_we    = we_q;
  assign arr_addr  = addr_q;
  assign arr_wdata = data_q;
  assign rdp_level = lvl;

  // R2
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(dat_wr));
  // R3
  eop_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sts_q[ST_EOP]);
  // R4
  no_write_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && busy) |=> !arr_we);
  // R11
  err_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_pend |=> ((sts_q[ST_SEQ:ST_OPER] & $past(sts_q[ST_SEQ:ST_OPER]))
                    == $past(sts_q[ST_SEQ:ST_OPER])));
  // R12
  rdp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_disable |-> (cfg_rdp == 8'hCC));
endmodule

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16, DATA_W = 32, NSECT = 12, SSH = 12, PROG_CYC = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0, dat_wr = 0, burst_pend = 0, cfg_prot_mode = 0;
  logic [5:0] reg_wdata = '0;
  logic [ADDR_W-1:0] dat_addr = '0;
  logic [1:0] dat_size = 2'd2;
  logic [DATA_W-1:0] dat_wdata = '0;
  logic [NSECT-1:0] cfg_prot = '1;
  logic [7:0] cfg_rdp = 8'hAA;
  logic [6:0] sts;
  logic [2:0] ctl;
  logic irq_eop, irq_err, arr_we, dbg_disable;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;
  logic [1:0] rdp_level;

  int checks = 0, fails = 0, cyc = 0;

  flash_prog_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSECT(NSECT),
    .SECT_SHIFT(SSH), .PSIZE(2'd2), .PROG_CYC(PROG_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dat_wr(dat_wr), .dat_addr(dat_addr),
    .dat_size(dat_size), .dat_wdata(dat_wdata), .burst_pend(burst_pend),
    .cfg_prot(cfg_prot), .cfg_prot_mode(cfg_prot_mode), .cfg_rdp(cfg_rdp),
    .sts(sts), .ctl(ctl), .irq_eop(irq_eop), .irq_err(irq_err),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .rdp_level(rdp_level), .dbg_disable(dbg_disable));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  bit [5:0] m_sts;
  bit [2:0] m_ctl;
  bit m_busy, m_we;
  int m_cnt;
  bit [ADDR_W-1:0] m_addr;
  bit [DATA_W-1:0] m_data;

  function automatic bit model_prot(input bit [ADDR_W-1:0] a);
    int idx = int'(a) / (1 << SSH);
    if (idx >= NSECT) return 1'b1;
    return cfg_prot_mode ? cfg_prot[idx] : !cfg_prot[idx];
  endfunction

  function automatic int model_rdp(input bit [7:0] b);
    if (b == 8'hAA) return 0;
    if (b == 8'hCC) return 2;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = '0; m_ctl = '0; m_busy = 0; m_we = 0; m_cnt = 0;
    end else begin
      bit [2:0] oc;
      bit ob, ep, ea, er;
      bit [5:0] setv, clrv;
      oc = m_ctl; ob = m_busy; setv = '0; clrv = '0; m_we = 0;
      cyc++;
      if (m_busy) begin
        if (m_cnt == 0) begin m_busy = 0; setv[0] = 1; end
        else m_cnt--;
      end
      if (dat_wr) begin
        if (ob || !oc[0]) setv[5] = 1;
        else begin
          ep = (dat_size != 2'd2);
          ea = (int'(dat_addr) % (1 << dat_size)) != 0;
          er = model_prot(dat_addr);
          setv[4] = ep; setv[3] = ea; setv[2] = er;
          if (ep || ea || er) setv[0] = 1;
          else begin
            m_busy = 1; m_cnt = PROG_CYC - 1; m_we = 1;
            m_addr = dat_addr; m_data = dat_wdata;
          end
        end
      end
      if (oc[2] && (setv[5:2] != 0)) setv[1] = 1;
      if (reg_wr && reg_sel && !burst_pend) clrv = reg_wdata;
      m_sts = (m_sts & ~clrv) | setv;
      if (reg_wr && !reg_sel) m_ctl = reg_wdata[2:0];
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 busy", sts[6], m_busy);
    chk("R2 arr_we", arr_we, m_we);
    if (m_we) begin
      chk("R2 arr_addr", arr_addr, m_addr);
      chk("R2 arr_wdata", arr_wdata, m_data);
    end
    chk("R3 eop", sts[0], m_sts[0]);
    chk("R3 irq_eop", irq_eop, m_sts[0] & m_ctl[1]);
    chk("R9 operr", sts[1], m_sts[1]);
    chk("R9 irq_err", irq_err, m_sts[1] & m_ctl[2]);
    chk("R7 prot", sts[2], m_sts[2]);
    chk("R6 align", sts[3], m_sts[3]);
    chk("R5 par", sts[4], m_sts[4]);
    chk("R4 seq", sts[5], m_sts[5]);
    chk("R13 ctl", ctl, m_ctl);
    chk("R12 level", rdp_level, model_rdp(cfg_rdp));
    chk("R12 dbg", dbg_disable, model_rdp(cfg_rdp) == 2);
  end

  task automatic reg_write(input bit sel, input bit [5:0] d);
    @(posedge clk); #2; reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #2; reg_wr = 0;
  endtask

  task automatic data_write(input bit [ADDR_W-1:0] a, input bit [1:0] sz,
                            input bit [DATA_W-1:0] d);
    @(posedge clk); #2; dat_wr = 1; dat_addr = a; dat_size = sz; dat_wdata = d;
    @(posedge clk); #2; dat_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 sts", sts, 0);
    chk("R1 ctl", ctl, 0);
    chk("R1 irq", {irq_eop, irq_err, arr_we}, 0);

    reg_write(0, 6'h03);                        // R13 pg + eop enable
    data_write(16'h0100, 2'd2, 32'hCAFE_0001);  // R2 legal program
    idle(PROG_CYC + 2);
    reg_write(1, 6'h01);                        // R10 clear eop
    #1; chk("R10 eop cleared", sts[0], 0);

    // R4 back-to-back: second write hits busy
    @(posedge clk); #2; dat_wr = 1; dat_addr = 16'h0104; dat_wdata = 32'h11;
    @(posedge clk); #2; dat_addr = 16'h0108; dat_wdata = 32'h22;
    @(posedge clk); #2; dat_wr = 0;
    idle(PROG_CYC + 2);
    reg_write(1, 6'h3F);

    reg_write(0, 6'h07);                        // R9 error enable on
    data_write(16'h0200, 2'd1, 32'h33);         // R5 size mismatch
    idle(2);
    reg_write(1, 6'h3F);
    data_write(16'h0102, 2'd2, 32'h44);         // R6 misaligned
    idle(2);
    reg_write(1, 6'h3F);

    idle(1); cfg_prot = 12'hFF7;                // R7 sector 3 write-protected
    data_write(16'h3000, 2'd2, 32'h55);
    idle(2);
    reg_write(1, 6'h3F);
    data_write(16'hC000, 2'd2, 32'h66);         // R7 sector index 12 out of range
    idle(2);

    // R11 clear blocked during burst
    begin
      logic [6:0] snap;
      idle(1); burst_pend = 1; #1; snap = sts;
      reg_write(1, 6'h3F);
      #1; chk("R11 clear blocked", sts, snap);
      burst_pend = 0;
    end
    reg_write(1, 6'h3F);
    #1; chk("R10 all cleared", sts[5:0], 0);

    cfg_prot_mode = 1; cfg_prot = 12'h008;      // R8 execute-only mode
    data_write(16'h3000, 2'd2, 32'h77);
    #1; chk("R8 sector 3 protected", sts[2], 1);
    reg_write(1, 6'h3F);
    data_write(16'h4000, 2'd2, 32'h88);         // R8 sector 4 writable
    #1; chk("R8 sector 4 writable", arr_we, 1);
    idle(PROG_CYC + 2);
    reg_write(1, 6'h3F);

    reg_write(0, 6'h06);                        // R4 pg cleared
    data_write(16'h0000, 2'd2, 32'h99);
    #1; chk("R4 seq when pg clear", sts[5], 1);
    reg_write(0, 6'h01);                        // R9 error enable off
    data_write(16'h0001, 2'd2, 32'h9A);
    idle(2);

    cfg_rdp = 8'hCC; idle(2);                   // R12 level 2
    #1; chk("R12 dbg at CC", dbg_disable, 1);
    cfg_rdp = 8'h00; idle(2);
    #1; chk("R12 level1", rdp_level, 1);
    cfg_rdp = 8'hAA; idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule